// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the data side of a processor that spends several clock cycles on each instruction. A single memory port carries both instruction fetches and data accesses, and a single ALU handles every computation. That ALU produces the incremented PC, the branch target, the effective address and the arithmetic results. Values that have to outlive a cycle are kept in holding registers: an instruction register, a memory data register, two operand registers and an ALU result register. An external sequencer supplies one set of discrete control strobes each cycle. It receives the current opcode and the ALU zero flag and uses them to choose its next step.

The supported instructions are register-register add, subtract, and, or and set-less-than, plus word load, word store, branch-if-equal and absolute jump. The memory port is a plain combinational interface with no valid/ready handshake. The block presents an address and a read or write strobe, and the memory has to return read data within the same cycle. No back-pressure exists: a stall has to be produced by the sequencer, which holds its strobes low. Control and status pins are plain levels.

Top module: `mc_dp_top`

## Requirements
- R1: After reset the PC, the instruction register and every holding register read zero, so `mem_addr` is 0 while `ctl_addr_sel`=0 and `op_code` is 0.
- R2: `mem_addr` carries the PC when `ctl_addr_sel`=0 and the registered ALU result when `ctl_addr_sel`=1.
- R3: ALU operand A is the PC when `ctl_a_sel`=0 and the A register when it is 1. Operand B depends on `ctl_b_sel`: 00 selects the B register, 01 the constant 4, 10 the sign-extended low 16 instruction bits, and 11 those same bits shifted left by two.
- R4: `ctl_alu_op` 00 adds and 01 subtracts. With 10, the low six instruction bits pick the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0). Any other code, and `ctl_alu_op`=11, adds. `alu_zero` is 1 exactly when the current ALU result is all zeros.
- R5: The instruction register loads `mem_rdata` only on a clock with `ctl_ir_wr`=1 and otherwise holds. `op_code` is its bits 31:26.
- R6: On every clock the A register loads register-file entry IR[25:21], the B register loads entry IR[20:16], the data register loads `mem_rdata`, and the result register loads the ALU output. `mem_wdata` is the B register.
- R7: With `ctl_rf_wr`=1 the register file is written at the clock edge. The destination is IR[15:11] when `ctl_dst_sel`=1 and IR[20:16] when it is 0. The data is the memory data register when `ctl_wb_sel`=1 and the result register when it is 0.
- R8: Register 0 always reads zero, and writes to it have no effect.
- R9: The PC is written when `ctl_pc_wr`=1, or when `ctl_pc_wr_cond`=1 and `alu_zero`=1. `ctl_pc_sel` selects the new value: 00 (and 11) the live ALU result, 01 the result register, 10 the jump target {PC[31:28], IR[25:0], 00}.
- R10: `mem_re` and `mem_we` follow `ctl_mem_rd` and `ctl_mem_wr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pc_wr | input | 1 | Unconditional PC write |
| ctl_pc_wr_cond | input | 1 | PC write when the ALU result is zero |
| ctl_addr_sel | input | 1 | Memory address source: 0 PC, 1 result register |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_wb_sel | input | 1 | Register write data: 0 result register, 1 memory data register |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_pc_sel | input | 2 | Next PC source |
| ctl_alu_op | input | 2 | ALU operation class |
| ctl_a_sel | input | 1 | ALU operand A source |
| ctl_b_sel | input | 2 | ALU operand B source |
| ctl_rf_wr | input | 1 | Register file write enable |
| ctl_dst_sel | input | 1 | Destination field: 0 IR[20:16], 1 IR[15:11] |
| op_code | output | 6 | Instruction register bits 31:26 |
| alu_zero | output | 1 | Current ALU result is zero |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |

## Verification
Assertions check five things on every cycle. The PC holds unless one of its write conditions is true, and a jump forms its target from the old PC and the instruction field. The instruction register either holds or captures the memory word. The data and result registers capture what was on their inputs one cycle earlier. A zero register field always produces a zero B operand. The bench scenarios have to show the arithmetic results for each function code across signed and unsigned corner operands, branches both taken and not taken with forward and backward offsets, both destination and write-back selections, and the correct sequencing of addresses and write data over whole load, store, branch and jump sequences.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
  // Instruction and data word width; the instruction field layout assumes 32.
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } alu_class_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] {
    BSRC_REG   = 2'b00,
    BSRC_FOUR  = 2'b01,
    BSRC_IMM   = 2'b10,
    BSRC_IMMX4 = 2'b11
  } bsrc_e;

  typedef enum logic [1:0] {
    PSRC_ALU  = 2'b00,
    PSRC_HOLD = 2'b01,
    PSRC_JUMP = 2'b10,
    PSRC_ALT  = 2'b11
  } pcsrc_e;

  localparam logic [5:0] FC_ADD = 6'b100000;
  localparam logic [5:0] FC_SUB = 6'b100010;
  localparam logic [5:0] FC_AND = 6'b100100;
  localparam logic [5:0] FC_OR  = 6'b100101;
  localparam logic [5:0] FC_SLT = 6'b101010;
endpackage

// File: rtl/mc_dp_alu_ctl.sv
module mc_dp_alu_ctl
  import mc_dp_pkg::*;
(
  input  logic [1:0] op_class,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  alu_fn_e fn_from_funct;

  // Function-code decode, used only for the register-register class.
  always_comb begin
    case (funct)
      FC_ADD:  fn_from_funct = FN_ADD;
      FC_SUB:  fn_from_funct = FN_SUB;
      FC_AND:  fn_from_funct = FN_AND;
      FC_OR:   fn_from_funct = FN_OR;
      FC_SLT:  fn_from_funct = FN_SLT;
      default: fn_from_funct = FN_ADD;
    endcase
  end

  always_comb begin
    case (alu_class_e'(op_class))
      AOP_ADD:   fn = FN_ADD;
      AOP_SUB:   fn = FN_SUB;
      AOP_FUNCT: fn = fn_from_funct;
      default:   fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/mc_dp_alu.sv
module mc_dp_alu
  import mc_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         is_zero
);
  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         lt_signed;

  assign sum       = opa + opb;
  assign diff      = opa - opb;
  assign lt_signed = $signed(opa) < $signed(opb);

  always_comb begin
    case (fn)
      FN_ADD:  res = sum;
      FN_SUB:  res = diff;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_SLT:  res = {{(W-1){1'b0}}, lt_signed};
      default: res = sum;
    endcase
  end

  assign is_zero = (res == '0);
endmodule

// File: rtl/mc_dp_regfile.sv
module mc_dp_regfile #(
  parameter int W       = 32,
  parameter int REG_CNT = 32,
  localparam int AW     = $clog2(REG_CNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);
  logic [REG_CNT*W-1:0] flat;

  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_ent
    if (gi == 0) begin : g_zero
      // Entry 0 is a constant zero; writes to it are dropped.
      assign flat[gi*W +: W] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && (wr_idx == AW'(gi)))
          q <= wr_data;
      end
      assign flat[gi*W +: W] = q;
    end
  end

  assign rd_a = flat[int'(rd_a_idx)*W +: W];
  assign rd_b = flat[int'(rd_b_idx)*W +: W];
endmodule

// File: rtl/mc_dp_top.sv
module mc_dp_top
  import mc_dp_pkg::*;
#(
  parameter int REG_CNT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_pc_wr,
  input  logic        ctl_pc_wr_cond,
  input  logic        ctl_addr_sel,
  input  logic        ctl_mem_rd,
  input  logic        ctl_mem_wr,
  input  logic        ctl_wb_sel,
  input  logic        ctl_ir_wr,
  input  logic [1:0]  ctl_pc_sel,
  input  logic [1:0]  ctl_alu_op,
  input  logic        ctl_a_sel,
  input  logic [1:0]  ctl_b_sel,
  input  logic        ctl_rf_wr,
  input  logic        ctl_dst_sel,
  output logic [5:0]  op_code,
  output logic        alu_zero,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        mem_re,
  output logic        mem_we
);
  localparam int W      = XLEN;
  localparam int REG_AW = $clog2(REG_CNT);

  // Architectural and holding state.
  logic [W-1:0] pc_q;
  logic [W-1:0] ir_q;
  logic [W-1:0] mdr_q;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] alu_out_q;

  // Register file read data and write port.
  logic [W-1:0]      rf_rd_a;
  logic [W-1:0]      rf_rd_b;
  logic [REG_AW-1:0] rf_wr_idx;
  logic [W-1:0]      rf_wr_data;

  // ALU operands, function and result.
  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_sx_x4;
  logic [W-1:0] alu_a;
  logic [W-1:0] alu_b;
  logic [W-1:0] alu_y;
  alu_fn_e      alu_fn;

  // Next-PC selection.
  logic [W-1:0] jump_tgt;
  logic [W-1:0] pc_nxt;
  logic         pc_en;

  // Instruction field extraction.
  assign op_code   = ir_q[31:26];
  assign imm_sx    = {{(W-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_sx_x4 = {imm_sx[W-3:0], 2'b00};
  assign jump_tgt  = {pc_q[W-1:W-4], ir_q[25:0], 2'b00};

  // Shared memory port: one address for fetch and data access.
  assign mem_addr  = ctl_addr_sel ? alu_out_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_re    = ctl_mem_rd;
  assign mem_we    = ctl_mem_wr;

  // Register file.
  assign rf_wr_idx  = ctl_dst_sel ? ir_q[11 +: REG_AW] : ir_q[16 +: REG_AW];
  assign rf_wr_data = ctl_wb_sel ? mdr_q : alu_out_q;

  mc_dp_regfile #(
    .W       (W),
    .REG_CNT (REG_CNT)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ir_q[21 +: REG_AW]),
    .rd_b_idx (ir_q[16 +: REG_AW]),
    .rd_a     (rf_rd_a),
    .rd_b     (rf_rd_b),
    .wr_en    (ctl_rf_wr),
    .wr_idx   (rf_wr_idx),
    .wr_data  (rf_wr_data)
  );

  // ALU operand selection.
  assign alu_a = ctl_a_sel ? a_q : pc_q;

  always_comb begin
    case (bsrc_e'(ctl_b_sel))
      BSRC_REG:   alu_b = b_q;
      BSRC_FOUR:  alu_b = W'(4);
      BSRC_IMM:   alu_b = imm_sx;
      default:    alu_b = imm_sx_x4;
    endcase
  end

  mc_dp_alu_ctl u_actl (
    .op_class (ctl_alu_op),
    .funct    (ir_q[5:0]),
    .fn       (alu_fn)
  );

  mc_dp_alu #(
    .W (W)
  ) u_alu (
    .opa     (alu_a),
    .opb     (alu_b),
    .fn      (alu_fn),
    .res     (alu_y),
    .is_zero (alu_zero)
  );

  // PC update: unconditional or zero-qualified.
  always_comb begin
    case (pcsrc_e'(ctl_pc_sel))
      PSRC_HOLD: pc_nxt = alu_out_q;
      PSRC_JUMP: pc_nxt = jump_tgt;
      default:   pc_nxt = alu_y;
    endcase
  end

  assign pc_en = ctl_pc_wr | (ctl_pc_wr_cond & alu_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (pc_en)
      pc_q <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ir_q <= '0;
    else if (ctl_ir_wr)
      ir_q <= mem_rdata;
  end

  // Holding registers refresh on every clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      mdr_q     <= mem_rdata;
      a_q       <= rf_rd_a;
      b_q       <= rf_rd_b;
      alu_out_q <= alu_y;
    end
  end
endmodule

// File: rtl/mc_dp_checker.sv
module mc_dp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_pc_wr,
  input logic        ctl_pc_wr_cond,
  input logic        ctl_ir_wr,
  input logic [1:0]  ctl_pc_sel,
  input logic        alu_zero,
  input logic [31:0] mem_rdata,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] mdr_q,
  input logic [31:0] b_q,
  input logic [31:0] alu_out_q,
  input logic [31:0] alu_y
);
  // R9: without a write condition the PC keeps its value.
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> $stable(pc_q));

  // R9: a jump joins the old PC top nibble with the instruction field.
  p_jump_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_wr && ctl_pc_sel == 2'b10) |=>
      pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00});

  // R5: the instruction register holds without its load strobe.
  p_ir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_wr |=> $stable(ir_q));

  // R5: with its load strobe it captures the memory word.
  p_ir_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_wr |=> ir_q == $past(mem_rdata));

  // R6: the data register captures memory on every clock.
  p_mdr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mdr_q == $past(mem_rdata));

  // R6: the result register captures the ALU output on every clock.
  p_res_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> alu_out_q == $past(alu_y));

  // R8: a zero source field yields a zero B operand.
  p_r0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[20:16] == 5'd0) |=> b_q == 32'd0);
endmodule

bind mc_dp_top mc_dp_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_pc_wr      (ctl_pc_wr),
  .ctl_pc_wr_cond (ctl_pc_wr_cond),
  .ctl_ir_wr      (ctl_ir_wr),
  .ctl_pc_sel     (ctl_pc_sel),
  .alu_zero       (alu_zero),
  .mem_rdata      (mem_rdata),
  .pc_q           (pc_q),
  .ir_q           (ir_q),
  .mdr_q          (mdr_q),
  .b_q            (b_q),
  .alu_out_q      (alu_out_q),
  .alu_y          (alu_y)
);

// File: tb/mc_dp_top_tb_top.sv
module mc_dp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_pc_wr, ctl_pc_wr_cond, ctl_addr_sel, ctl_mem_rd, ctl_mem_wr;
  logic        ctl_wb_sel, ctl_ir_wr, ctl_a_sel, ctl_rf_wr, ctl_dst_sel;
  logic [1:0]  ctl_pc_sel, ctl_alu_op, ctl_b_sel;
  logic [5:0]  op_code;
  logic        alu_zero;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;

  logic [31:0] mem [0:63];
  logic [31:0] breg [0:31];
  logic [31:0] exp_pc;
  logic [31:0] dec_tgt;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:2]];

  mc_dp_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_pc_wr(ctl_pc_wr), .ctl_pc_wr_cond(ctl_pc_wr_cond),
    .ctl_addr_sel(ctl_addr_sel), .ctl_mem_rd(ctl_mem_rd), .ctl_mem_wr(ctl_mem_wr),
    .ctl_wb_sel(ctl_wb_sel), .ctl_ir_wr(ctl_ir_wr), .ctl_pc_sel(ctl_pc_sel),
    .ctl_alu_op(ctl_alu_op), .ctl_a_sel(ctl_a_sel), .ctl_b_sel(ctl_b_sel),
    .ctl_rf_wr(ctl_rf_wr), .ctl_dst_sel(ctl_dst_sel),
    .op_code(op_code), .alu_zero(alu_zero),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_ctl();
    ctl_pc_wr = 0; ctl_pc_wr_cond = 0; ctl_addr_sel = 0; ctl_mem_rd = 0;
    ctl_mem_wr = 0; ctl_wb_sel = 0; ctl_ir_wr = 0; ctl_a_sel = 0;
    ctl_rf_wr = 0; ctl_dst_sel = 0; ctl_pc_sel = 2'b00; ctl_alu_op = 2'b00;
    ctl_b_sel = 2'b00;
  endtask

  // Controls are applied after a falling edge and captured at the next rising edge.
  task automatic step();
    @(negedge clk);
    clr_ctl();
  endtask

  function automatic logic [31:0] sx(input logic [31:0] ins);
    return {{16{ins[15]}}, ins[15:0]};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [5:0] f);
    case (f)
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  task automatic fetch_decode(input logic [31:0] ins);
    step();
    mem[exp_pc[7:2]] = ins;
    ctl_ir_wr = 1; ctl_mem_rd = 1; ctl_b_sel = 2'b01; ctl_pc_wr = 1;
    #2;
    chk("R9 R2 fetch address", mem_addr, exp_pc);
    chk("R10 read strobe", {31'd0, mem_re}, 32'd1);
    exp_pc = exp_pc + 32'd4;
    step();
    ctl_b_sel = 2'b11;
    #2;
    chk("R5 opcode", {26'd0, op_code}, {26'd0, ins[31:26]});
    dec_tgt = exp_pc + (sx(ins) << 2);
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [15:0] addr);
    logic [31:0] ins = {6'b100011, 5'd0, rt, addr};
    fetch_decode(ins);
    step(); ctl_a_sel = 1; ctl_b_sel = 2'b10;
    step(); ctl_addr_sel = 1; ctl_mem_rd = 1;
    #2;
    chk("R2 R3 load address", mem_addr, {16'd0, addr});
    chk("R5 opcode held during data read", {26'd0, op_code}, 32'd35);
    step(); ctl_rf_wr = 1; ctl_wb_sel = 1; ctl_dst_sel = 0;
    if (rt != 0) breg[rt] = mem[addr[7:2]];
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [15:0] addr);
    logic [31:0] ins = {6'b101011, 5'd0, rt, addr};
    fetch_decode(ins);
    step(); ctl_a_sel = 1; ctl_b_sel = 2'b10;
    step(); ctl_addr_sel = 1; ctl_mem_wr = 1;
    #2;
    chk("R2 store address", mem_addr, {16'd0, addr});
    chk("R6 R7 R8 store data", mem_wdata, breg[rt]);
    chk("R10 write strobe", {31'd0, mem_we}, 32'd1);
  endtask

  task automatic do_rr(input logic [4:0] rs, input logic [4:0] rt,
                       input logic [4:0] rd, input logic [5:0] f);
    logic [31:0] ins = {6'b000000, rs, rt, rd, 5'd0, f};
    logic [31:0] r = model(breg[rs], breg[rt], f);
    fetch_decode(ins);
    step(); ctl_a_sel = 1; ctl_b_sel = 2'b00; ctl_alu_op = 2'b10;
    #2;
    chk("R4 zero flag on function result", {31'd0, alu_zero}, {31'd0, r == 0});
    step(); ctl_rf_wr = 1; ctl_dst_sel = 1; ctl_wb_sel = 0;
    if (rd != 0) breg[rd] = r;
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    logic [31:0] ins = {6'b000100, rs, rt, off};
    logic eq = (breg[rs] == breg[rt]);
    fetch_decode(ins);
    step(); ctl_a_sel = 1; ctl_alu_op = 2'b01; ctl_pc_wr_cond = 1; ctl_pc_sel = 2'b01;
    #2;
    chk("R4 compare zero", {31'd0, alu_zero}, {31'd0, eq});
    if (eq) exp_pc = dec_tgt;
  endtask

  task automatic do_j(input logic [25:0] tgt);
    fetch_decode({6'b000010, tgt});
    step(); ctl_pc_wr = 1; ctl_pc_sel = 2'b10;
    exp_pc = {exp_pc[31:28], tgt, 2'b00};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    logic [5:0]  fcs  [5];
    vals = '{32'd0, 32'd1, 32'd7, 32'h7fffffff, 32'h80000000, 32'hffffffff,
             32'h12345678, 32'd5};
    fcs  = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    for (int k = 0; k < 64; k++) mem[k] = 32'd0;
    for (int k = 0; k < 32; k++) breg[k] = 32'd0;
    clr_ctl();
    rst_n = 0;
    exp_pc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    // R1: cleared state visible at the ports.
    chk("R1 reset address", mem_addr, 32'd0);
    chk("R1 reset opcode", {26'd0, op_code}, 32'd0);
    chk("R1 reset zero flag", {31'd0, alu_zero}, 32'd1);

    // R8: write to register 0 is dropped; R4: unlisted code adds; R9: jump to a nonzero target.
    mem[32] = 32'h0000_0123;
    do_lw(5'd1, 16'h0080);
    do_sw(5'd1, 16'h0088);
    do_rr(5'd1, 5'd1, 5'd0, 6'b100000);
    do_sw(5'd0, 16'h0088);
    do_rr(5'd1, 5'd1, 5'd5, 6'b000000);
    do_sw(5'd5, 16'h0088);
    do_j(26'd8);
    do_j(26'd0);

    // Sweep operand pairs across every function code, then branch both ways.
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        mem[32] = vals[i];
        mem[33] = vals[j];
        do_lw(5'd1, 16'h0080);
        do_lw(5'd2, 16'h0084);
        for (int f = 0; f < 5; f++) begin
          do_rr(5'd1, 5'd2, 5'd3, fcs[f]);
          do_sw(5'd3, 16'h0088);
        end
        do_beq(5'd1, 5'd2, ((i + j) % 2 == 0) ? 16'h0001 : 16'hffff);
        do_j(26'd0);
      end
    end
    step();
    #2;
    chk("R9 final PC", mem_addr, exp_pc);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule